// File: doc/BRIEF.md
# SDRAM Periodic Refresh Sequencer

This block keeps SDRAM contents alive by taking over a shared command bus at a fixed interval. A free-running interval timer marks each refresh deadline. When a deadline passes, the block raises a request towards the command arbiter and holds it. Once the arbiter grants the bus, the block closes every open row with a precharge-all command. It waits the row-precharge time, issues an auto-refresh command, waits the refresh-cycle time, and then drops its request.

The arbiter may grant after any delay. A deadline that passes while a request is still waiting for a grant is merged into that request. A deadline that passes while the command sequence is running is remembered. It is served by a fresh request once the current one has been released.

The command bundle is combinational from the sequencer state and the grant input, so the precharge-all command can appear in the very cycle the grant arrives.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After synchronous reset is released, `req` rises exactly T_REFI clock edges later (cycle T_REFI when the first edge after release is counted as cycle 1). While idle, it rises again at every later T_REFI boundary.
- R2: Once raised, `req` stays high without a gap until the release point of R5, whatever the grant delay.
- R3: Precharge-all is driven as ras_n=0, cas_n=1, we_n=0, with address bit 10 = 1, all other address bits 0 and bank 0. It appears in the first cycle in which `ack` is high while `req` is high.
- R4: Auto-refresh is driven as ras_n=0, cas_n=0, we_n=1, with address 0 and bank 0. It appears exactly T_RP cycles after the precharge-all cycle.
- R5: `req` is low exactly T_RFC cycles after the auto-refresh cycle.
- R6: In every other cycle the bundle is NOP: ras_n, cas_n and we_n high, with address and bank 0. Each request produces exactly one precharge-all and one auto-refresh.
- R7: A deadline that passes while `req` waits for `ack` is merged into the pending request. Only one sequence is issued, and the next request comes at the following T_REFI boundary.
- R8: A deadline that passes between the precharge-all cycle and the release cycle is kept. `req` is low for exactly one cycle after release and then rises again.
- R9: While `rst` is high, `req` is low and the bundle is NOP. After release, the interval timing restarts as in R1.
- R10: If `ack` is already high in the first cycle `req` is high, precharge-all is issued in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack | input | 1 | Bus grant from the command arbiter |
| req | output | 1 | Bus request to the command arbiter |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Row/column address (bit 10 selects all banks on precharge) |

## Verification
Two functions of the block can fall in the same cycle or window: an interval deadline and the grant-driven command sequence.

The bench provokes the overlap in two ways. In the first, it withholds the grant across a whole interval, so that a deadline passes while the request waits. In the second, it grants late enough that the next deadline lands inside the refresh-cycle wait.

The bench judges each case by three things: the exact cycles of request rise and fall, a one-to-one match of every issued command against the queue of expected commands, and the position of the next request after release. A zero-delay grant and a reset in the middle of the run complete the set.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;
   typedef enum logic [1:0] {
      RC_NOP     = 2'd0,
      RC_PRE_ALL = 2'd1,
      RC_AUTO    = 2'd2
   } rf_cmd_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_WAIT = 2'd1,
      SQ_TRP  = 2'd2,
      SQ_TRFC = 2'd3
   } rf_state_e;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
   parameter int T_REFI = 100
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CW = (T_REFI > 2) ? $clog2(T_REFI) : 1;

   logic [CW-1:0] cnt;

   generate
      if (T_REFI < 2) begin : g_bad
         $error("T_REFI must be at least 2");
      end
      if ((1 << CW) == T_REFI) begin : g_wrap
         // power-of-two interval: natural roll-over, no reload compare
         always_ff @(posedge clk) begin
            if (rst) cnt <= '0;
            else     cnt <= cnt + 1'b1;
         end
      end else begin : g_reload
         always_ff @(posedge clk) begin
            if (rst)                                 cnt <= '0;
            else if (cnt == CW'(T_REFI - 1))         cnt <= '0;
            else                                     cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   assign tick = (cnt == CW'(T_REFI - 1));

   // R1
   timer_gap_chk: assert property (@(posedge clk) disable iff (rst)
      tick |=> (!tick && cnt == '0));
endmodule

// File: rtl/refresh_seq_fsm.sv
module refresh_seq_fsm
   import sdram_refresh_pkg::*;
#(
   parameter int T_RP  = 3,
   parameter int T_RFC = 5
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    tick,
   input  logic    ack,
   output logic    req,
   output rf_cmd_e cmd
);
   localparam int TMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int DW   = $clog2(TMAX + 1);

   rf_state_e      st;
   logic [DW-1:0]  dly;
   logic           owed;

   generate
      if (T_RP < 1)  begin : g_bad_rp  $error("T_RP must be at least 1");  end
      if (T_RFC < 2) begin : g_bad_rfc $error("T_RFC must be at least 2"); end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= SQ_IDLE;
         dly  <= '0;
         owed <= 1'b0;
      end else begin
         case (st)
            SQ_IDLE: begin
               if (tick || owed) st <= SQ_WAIT;
               owed <= 1'b0;
            end
            SQ_WAIT: begin
               if (ack) begin
                  st  <= SQ_TRP;
                  dly <= DW'(T_RP - 1);
               end
            end
            SQ_TRP: begin
               if (tick) owed <= 1'b1;
               if (dly == '0) begin
                  st  <= SQ_TRFC;
                  dly <= DW'(T_RFC - 1);
               end else begin
                  dly <= dly - 1'b1;
               end
            end
            default: begin
               if (tick) owed <= 1'b1;
               if (dly == DW'(1)) st  <= SQ_IDLE;
               else               dly <= dly - 1'b1;
            end
         endcase
      end
   end

   assign req = (st != SQ_IDLE);

   always_comb begin
      cmd = RC_NOP;
      if (st == SQ_WAIT && ack)             cmd = RC_PRE_ALL;
      else if (st == SQ_TRP && dly == '0)   cmd = RC_AUTO;
   end

   // R8
   owed_rearm_chk: assert property (@(posedge clk) disable iff (rst)
      (st == SQ_IDLE && owed) |=> req);
   // R7
   wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st == SQ_WAIT && !ack) |=> (st == SQ_WAIT));
endmodule

// File: rtl/sdram_cmd_encode.sv
module sdram_cmd_encode
   import sdram_refresh_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BANK_W = 2,
   parameter int AP_BIT = 10
) (
   input  rf_cmd_e            cmd,
   output logic               ras_n,
   output logic               cas_n,
   output logic               we_n,
   output logic [BANK_W-1:0]  ba,
   output logic [ADDR_W-1:0]  addr
);
   generate
      if (AP_BIT >= ADDR_W) begin : g_bad
         $error("address too narrow for the all-banks bit");
      end
   endgenerate

   always_comb begin
      ras_n = 1'b1;
      cas_n = 1'b1;
      we_n  = 1'b1;
      ba    = '0;
      addr  = '0;
      case (cmd)
         RC_PRE_ALL: begin
            ras_n        = 1'b0;
            we_n         = 1'b0;
            addr[AP_BIT] = 1'b1;
         end
         RC_AUTO: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
   import sdram_refresh_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BANK_W = 2,
   parameter int T_RP   = 3,
   parameter int T_REFI = 100,
   parameter int T_RFC  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ack,
   output logic              req,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] ba,
   output logic [ADDR_W-1:0] addr
);
   localparam int LIM = T_RP + T_RFC + 1;
   localparam int SW  = $clog2(LIM + 1);

   logic    tick;
   rf_cmd_e cmd;

   refresh_interval_timer #(.T_REFI(T_REFI)) u_timer (
      .clk(clk), .rst(rst), .tick(tick));

   refresh_seq_fsm #(.T_RP(T_RP), .T_RFC(T_RFC)) u_fsm (
      .clk(clk), .rst(rst), .tick(tick), .ack(ack), .req(req), .cmd(cmd));

   sdram_cmd_encode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .AP_BIT(10)) u_enc (
      .cmd(cmd), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr));

   // pin-level decode and spacing counters for the checks below
   logic          is_pre, is_ref, is_nop;
   logic [SW-1:0] since_pre, since_ref;

   assign is_pre = !ras_n &&  cas_n && !we_n;
   assign is_ref = !ras_n && !cas_n &&  we_n;
   assign is_nop =  ras_n &&  cas_n &&  we_n && addr == '0 && ba == '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_pre <= '0;
         since_ref <= '0;
      end else begin
         if (is_pre)                                      since_pre <= SW'(1);
         else if (since_pre != '0 && since_pre < SW'(LIM)) since_pre <= since_pre + 1'b1;
         if (is_ref)                                      since_ref <= SW'(1);
         else if (since_ref != '0 && since_ref < SW'(LIM)) since_ref <= since_ref + 1'b1;
      end
   end

   // R3
   pre_grant_chk: assert property (@(posedge clk) disable iff (rst)
      is_pre |-> (req && ack));
   // R3
   pre_first_ack_chk: assert property (@(posedge clk) disable iff (rst)
      (req && ack && $past(req && !ack)) |-> is_pre);
   // R4
   ref_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      is_ref |-> (since_pre == SW'(T_RP)));
   // R5
   release_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(req) |-> (since_ref == SW'(T_RFC)));
   // R6
   idle_nop_chk: assert property (@(posedge clk) disable iff (rst)
      !(req && ack) |-> is_nop);
   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!req && is_nop));
endmodule

// File: tb/sim_sdram_refresh_seq.sv
module sim_sdram_refresh_seq;
   localparam int ADDR_W = 13;
   localparam int BANK_W = 2;
   localparam int T_RP   = 3;
   localparam int T_REFI = 100;
   localparam int T_RFC  = 5;

   typedef struct { int kind; int cyc; } ev_t;   // kind: 0 pre-all, 1 refresh, 2 release

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ack = 1'b0;
   logic req, ras_n, cas_n, we_n;
   logic [BANK_W-1:0] ba;
   logic [ADDR_W-1:0] addr;

   int  cyc = 0;
   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   bit  prev_req = 1'b0;
   ev_t expq[$];

   always #2.5 clk = ~clk;   // 200 MHz

   sdram_refresh_seq #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .T_RP(T_RP),
      .T_REFI(T_REFI), .T_RFC(T_RFC)) u0 (
      .clk(clk), .rst(rst), .ack(ack), .req(req), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr));

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor: pops expected events as the design produces them
   always @(negedge clk) begin
      int kind;
      kind = -1;
      if (rst) begin
         check(ras_n && cas_n && we_n && addr == '0 && ba == '0,
               "R9 NOP in reset", {ras_n, cas_n, we_n}, 7);
         prev_req = 1'b0;
      end else begin
         if (!ras_n && cas_n && !we_n) begin
            kind = 0;
            check(addr == ADDR_W'(1 << 10) && ba == '0, "R3 pre-all fields", int'(addr), 1 << 10);
         end else if (!ras_n && !cas_n && we_n) begin
            kind = 1;
            check(addr == '0 && ba == '0, "R4 refresh fields", int'(addr), 0);
         end else if (prev_req && !req) begin
            kind = 2;
         end else if (!(ras_n && cas_n && we_n && addr == '0 && ba == '0)) begin
            check(1'b0, "R6 stray command", {ras_n, cas_n, we_n}, 7);
         end
         if (kind >= 0) begin
            if (expq.size() == 0) begin
               check(1'b0, "R6 unexpected event", kind, -1);
            end else begin
               ev_t e;
               e = expq.pop_front();
               check(e.kind == kind, "R6 event order", kind, e.kind);
               check(e.cyc == cyc, "R3/R4/R5 event cycle", cyc, e.cyc);
            end
         end
         prev_req = req;
      end
   end

   // driver: wait for req, grant after a delay, push expected events, release
   task automatic grant(input int exp_rise, input int delay);
      int g;
      bit held;
      do begin
         @(posedge clk); #1;
      end while (!req);
      check(cyc == exp_rise, "R1/R8 req rise cycle", cyc, exp_rise);
      held = 1'b1;
      for (int i = 0; i < delay; i++) begin
         @(posedge clk); #1;
         if (!req) held = 1'b0;
      end
      check(held, "R2/R7 req held while waiting", held, 1);
      ack = 1'b1;
      g = cyc;
      expq.push_back('{0, g});
      expq.push_back('{1, g + T_RP});
      expq.push_back('{2, g + T_RP + T_RFC});
      do begin
         @(posedge clk); #1;
      end while (req);
      check(cyc == g + T_RP + T_RFC, "R5 release cycle", cyc, g + T_RP + T_RFC);
      ack = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(req == 1'b0, "R9 req low in reset", req, 0);
      rst = 1'b0;
      grant(T_REFI, 4);                   // R1: first interval, short delay
      grant(2 * T_REFI, 110);             // R7: deadline 300 merged while waiting
      grant(4 * T_REFI, 95);              // R7 next at 400; R8 deadline inside sequence
      grant(4 * T_REFI + 95 + T_RP + T_RFC + 1, 2);   // R8: one-cycle gap
      grant(6 * T_REFI, 0);               // R10: grant in the rise cycle
      while (cyc < 650) begin
         @(posedge clk); #1;
      end
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check(req == 1'b0, "R9 req low after mid-run reset", req, 0);
      rst = 1'b0;
      grant(T_REFI, 1);                   // R9: interval restarts
      repeat (3) @(posedge clk);
      #1;
      check(expq.size() == 0, "R6 all expected events seen", expq.size(), 0);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
   end
endmodule